// File: doc/BRIEF.md
# Exhaustive Approximate-Multiplier Error Sweep Engine

This block measures how far an approximate 8-bit unsigned multiplier strays from the exact product across its whole input space. A single start pulse makes it walk through all 65,536 operand pairs, one pair per clock. Each pair goes through a combinational approximate multiplier. The exact product is formed alongside it. The signed error distance (approximate minus exact) then feeds five running totals.

When the sweep ends, a done flag rises and the totals stay put. The totals are the sum of absolute errors, the number of samples that are wrong, the largest absolute error, the sum of squared errors and the number of samples whose exact product is zero. Host software divides these totals by the sample count to get the mean, normalised (divisor 65,025) and root-mean-square figures. It uses the zero-product count to leave those samples out of a relative-error average.

The approximate multiplier keeps every partial-product column at or above `LOW_COLS` exact. The columns below it are either dropped or reduced to one OR per column, and they pass no carry upward. The choice is made at elaboration.

Top module: `errsweep_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and all five result outputs read zero.
- R2: A `start` pulse seen while `busy` is low begins a sweep. The edge that accepts it sets `busy`, clears `done` and clears all five results to zero.
- R3: One operand pair is accumulated per clock. The 65,536th rising edge after the accepting edge sets `done` and clears `busy`, and the two are never high together.
- R4: The approximate product sums each partial product a[i]&b[j] with weight 2^(i+j) exactly when i+j >= LOW_COLS (default 4). For each column k below that, result bit k is 0 when LOW_MODE is truncate. It is the OR of that column's partial products when LOW_MODE is OR. No carry leaves the lower columns.
- R5: `abs_err_sum` equals the sum over all pairs of |approximate − exact|.
- R6: `err_count` equals the number of pairs whose approximate product differs from the exact product.
- R7: `max_abs_err` equals the largest |approximate − exact| over all pairs.
- R8: `sq_err_sum` equals the sum over all pairs of (approximate − exact)^2.
- R9: `zero_prod_count` equals the number of pairs whose exact product is zero. That is 511 for 8-bit operands.
- R10: A `start` pulse while `busy` is high is ignored, including one in the last busy cycle. The final totals and the completion time are unchanged.
- R11: `done` and the results hold until the next accepted `start`. A `start` while `done` is high begins a fresh sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a sweep |
| busy | output | 1 | High while the sweep is running |
| done | output | 1 | High once the last pair is accumulated, until the next start |
| abs_err_sum | output | 32 | Sum of absolute error distances |
| err_count | output | 17 | Count of pairs with non-zero error |
| max_abs_err | output | 16 | Largest absolute error distance |
| sq_err_sum | output | 48 | Sum of squared error distances |
| zero_prod_count | output | 17 | Count of pairs whose exact product is zero |

## Verification
Two events can land on the same clock edge: a new `start` request, and the accumulation of the final pair that raises `done`. The bench raises `start` in the very cycle that the pair (255, 255) is being accumulated, and also in the middle of a sweep. It then requires that completion comes at exactly 65,536 edges after the accepting edge and that `done` stays high afterwards. The reverse overlap is also covered: a `start` while `done` is high must restart the sweep and clear every total on that same edge. Both lower-region variants run side by side, and their totals are compared with a model that computes the approximate product differently, by subtracting the lower columns from the exact product.

// File: rtl/errsweep_pkg.sv
package errsweep_pkg;

  // How the partial-product columns below LOW_COLS are reduced.
  typedef enum logic {
    LOW_TRUNC = 1'b0,
    LOW_OR    = 1'b1
  } low_mode_e;

endpackage

// File: rtl/errsweep_approx_mul.sv
module errsweep_approx_mul
  import errsweep_pkg::*;
#(
  parameter int        W        = 8,
  parameter int        LOW_COLS = 4,
  parameter low_mode_e LOW_MODE = LOW_TRUNC
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  // Exact sum of every partial product whose column is at or above LOW_COLS.
  function automatic logic [PW-1:0] upper_sum(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        if ((i + j) >= LOW_COLS && x[i] && y[j]) begin
          acc = acc + (PW'(1) << (i + j));
        end
      end
    end
    return acc;
  endfunction

  // OR of all partial products that fall into column col.
  function automatic logic column_any(input logic [W-1:0] x, input logic [W-1:0] y, input int col);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        if ((i + j) == col) begin
          hit = hit | (x[i] & y[j]);
        end
      end
    end
    return hit;
  endfunction

  logic [LOW_COLS-1:0] low_bits;

  for (genvar c = 0; c < LOW_COLS; c++) begin : g_low
    if (LOW_MODE == LOW_OR) begin : g_or
      assign low_bits[c] = column_any(a, b, c);
    end else begin : g_trunc
      assign low_bits[c] = 1'b0;
    end
  end

  assign prod = upper_sum(a, b) | {{(PW-LOW_COLS){1'b0}}, low_bits};

endmodule

// File: rtl/errsweep_seq.sv
module errsweep_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b,
  output logic         start_accept,
  output logic         last_pair
);
  // Operand A is the inner loop, operand B the outer loop.
  assign start_accept = start & ~busy;
  assign last_pair    = busy & (&op_a) & (&op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      op_a <= '0;
      op_b <= '0;
    end else if (start_accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      op_a <= '0;
      op_b <= '0;
    end else if (busy) begin
      if (last_pair) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        op_a <= op_a + 1'b1;
        if (&op_a) begin
          op_b <= op_b + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/errsweep_accum.sv
module errsweep_accum #(
  parameter int W         = 8,
  parameter int ABS_SUM_W = 32,
  parameter int SQ_SUM_W  = 48,
  parameter int CNT_W     = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic [2*W-1:0]       approx,
  input  logic [2*W-1:0]       exact,
  output logic                 ed_nonzero,
  output logic [ABS_SUM_W-1:0] abs_err_sum,
  output logic [CNT_W-1:0]     err_count,
  output logic [2*W-1:0]       max_abs_err,
  output logic [SQ_SUM_W-1:0]  sq_err_sum,
  output logic [CNT_W-1:0]     zero_prod_count
);
  localparam int PW  = 2 * W;
  localparam int SQW = 2 * PW;

  function automatic logic [PW-1:0] magnitude(input logic [PW-1:0] x, input logic [PW-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [SQW-1:0] square(input logic [PW-1:0] m);
    return SQW'(m) * SQW'(m);
  endfunction

  logic [PW-1:0]  mag;
  logic [SQW-1:0] mag_sq;
  logic           exact_zero;

  assign mag        = magnitude(approx, exact);
  assign mag_sq     = square(mag);
  assign ed_nonzero = (approx != exact);
  assign exact_zero = (exact == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abs_err_sum     <= '0;
      err_count       <= '0;
      max_abs_err     <= '0;
      sq_err_sum      <= '0;
      zero_prod_count <= '0;
    end else if (clear) begin
      abs_err_sum     <= '0;
      err_count       <= '0;
      max_abs_err     <= '0;
      sq_err_sum      <= '0;
      zero_prod_count <= '0;
    end else if (step) begin
      abs_err_sum     <= abs_err_sum + ABS_SUM_W'(mag);
      err_count       <= err_count + CNT_W'(ed_nonzero);
      sq_err_sum      <= sq_err_sum + SQ_SUM_W'(mag_sq);
      zero_prod_count <= zero_prod_count + CNT_W'(exact_zero);
      if (mag > max_abs_err) begin
        max_abs_err <= mag;
      end
    end
  end

endmodule

// File: rtl/errsweep_engine.sv
module errsweep_engine
  import errsweep_pkg::*;
#(
  parameter int        W         = 8,
  parameter int        LOW_COLS  = 4,
  parameter low_mode_e LOW_MODE  = LOW_TRUNC,
  parameter int        ABS_SUM_W = 32,
  parameter int        SQ_SUM_W  = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [ABS_SUM_W-1:0] abs_err_sum,
  output logic [2*W:0]         err_count,
  output logic [2*W-1:0]       max_abs_err,
  output logic [SQ_SUM_W-1:0]  sq_err_sum,
  output logic [2*W:0]         zero_prod_count
);
  localparam int PW    = 2 * W;
  localparam int CNT_W = PW + 1;

  logic [W-1:0]  op_a;
  logic [W-1:0]  op_b;
  logic [PW-1:0] approx_prod;
  logic [PW-1:0] exact_prod;
  logic          start_accept;
  logic          last_pair;
  logic          sample_mismatch;

  errsweep_seq #(.W(W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .op_a         (op_a),
    .op_b         (op_b),
    .start_accept (start_accept),
    .last_pair    (last_pair)
  );

  errsweep_approx_mul #(
    .W        (W),
    .LOW_COLS (LOW_COLS),
    .LOW_MODE (LOW_MODE)
  ) u_mul (
    .a    (op_a),
    .b    (op_b),
    .prod (approx_prod)
  );

  assign exact_prod = PW'(op_a) * PW'(op_b);

  errsweep_accum #(
    .W         (W),
    .ABS_SUM_W (ABS_SUM_W),
    .SQ_SUM_W  (SQ_SUM_W),
    .CNT_W     (CNT_W)
  ) u_acc (
    .clk             (clk),
    .rst_n           (rst_n),
    .clear           (start_accept),
    .step            (busy),
    .approx          (approx_prod),
    .exact           (exact_prod),
    .ed_nonzero      (sample_mismatch),
    .abs_err_sum     (abs_err_sum),
    .err_count       (err_count),
    .max_abs_err     (max_abs_err),
    .sq_err_sum      (sq_err_sum),
    .zero_prod_count (zero_prod_count)
  );

endmodule

// File: rtl/errsweep_engine_chk.sv
module errsweep_engine_chk #(
  parameter int ABS_SUM_W = 32,
  parameter int SQ_SUM_W  = 48,
  parameter int CNT_W     = 17,
  parameter int PW        = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 start_accept,
  input logic                 last_pair,
  input logic                 sample_mismatch,
  input logic [ABS_SUM_W-1:0] abs_err_sum,
  input logic [CNT_W-1:0]     err_count,
  input logic [PW-1:0]        max_abs_err,
  input logic [SQ_SUM_W-1:0]  sq_err_sum,
  input logic [CNT_W-1:0]     zero_prod_count
);

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (busy && !done && abs_err_sum == '0 && err_count == '0 &&
                      max_abs_err == '0 && sq_err_sum == '0 && zero_prod_count == '0));

  assert_finish_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_pair |=> (done && !busy));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_pair) |=> busy);

  assert_mismatch_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sample_mismatch) |=> err_count == $past(err_count) + CNT_W'(1));

  assert_max_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> max_abs_err >= $past(max_abs_err));

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(abs_err_sum) && $stable(sq_err_sum)));

endmodule

bind errsweep_engine errsweep_engine_chk #(
  .ABS_SUM_W (ABS_SUM_W),
  .SQ_SUM_W  (SQ_SUM_W),
  .CNT_W     (CNT_W),
  .PW        (PW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .busy            (busy),
  .done            (done),
  .start_accept    (start_accept),
  .last_pair       (last_pair),
  .sample_mismatch (sample_mismatch),
  .abs_err_sum     (abs_err_sum),
  .err_count       (err_count),
  .max_abs_err     (max_abs_err),
  .sq_err_sum      (sq_err_sum),
  .zero_prod_count (zero_prod_count)
);

// File: tb/errsweep_engine_bench.sv
module errsweep_engine_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int  LC        = 4;
  localparam int  SWEEP_LEN = 65536;
  localparam int  WATCHDOG  = 190000;

  typedef struct {
    longint abs_sum;
    longint nz;
    longint maxe;
    longint sq_sum;
    longint zeros;
  } totals_t;

  typedef struct {
    longint  done_cyc;
    totals_t t_trunc;
    totals_t t_or;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;

  logic        busy0, done0, busy1, done1;
  logic [31:0] abs0, abs1;
  logic [16:0] cnt0, cnt1, zc0, zc1;
  logic [15:0] max0, max1;
  logic [47:0] sq0, sq1;

  int     n_checks = 0;
  int     n_fail   = 0;
  int     completions = 0;
  longint cyc = 0;
  bit     finished = 0;
  item_t  sb_q[$];
  totals_t exp_tr, exp_or;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  errsweep_engine u_errsweep_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy0), .done(done0),
    .abs_err_sum(abs0), .err_count(cnt0), .max_abs_err(max0),
    .sq_err_sum(sq0), .zero_prod_count(zc0)
  );

  errsweep_engine #(.LOW_MODE(errsweep_pkg::LOW_OR)) u_errsweep_engine_or (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy1), .done(done1),
    .abs_err_sum(abs1), .err_count(cnt1), .max_abs_err(max1),
    .sq_err_sum(sq1), .zero_prod_count(zc1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference model: the exact product minus the lower columns, plus the OR bits.
  function automatic totals_t model(input bit or_mode);
    totals_t t;
    t = '{0, 0, 0, 0, 0};
    for (int bv = 0; bv < 256; bv++) begin
      for (int av = 0; av < 256; av++) begin
        logic [7:0] xa, xb;
        longint ex, dropped, orbits, ap, ed, mg;
        xa = av[7:0];
        xb = bv[7:0];
        ex = longint'(av) * longint'(bv);
        dropped = 0;
        orbits  = 0;
        for (int k = 0; k < LC; k++) begin
          int cnt;
          cnt = 0;
          for (int i = 0; i <= k; i++) begin
            if (i < 8 && (k - i) < 8 && xa[i] && xb[k-i]) cnt++;
          end
          dropped += longint'(cnt) << k;
          if (or_mode && cnt > 0) orbits += longint'(1) << k;
        end
        ap = ex - dropped + orbits;
        ed = ap - ex;
        mg = (ed < 0) ? -ed : ed;
        t.abs_sum += mg;
        t.sq_sum  += ed * ed;
        if (ed != 0) t.nz++;
        if (mg > t.maxe) t.maxe = mg;
        if (ex == 0) t.zeros++;
      end
    end
    return t;
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Driver: pushes the expectation, then pulses start (called at a negedge).
  task automatic launch();
    item_t it;
    it.done_cyc = cyc + 1 + SWEEP_LEN;
    it.t_trunc  = exp_tr;
    it.t_or     = exp_or;
    sb_q.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic compare(input string tag, input totals_t e, input logic [31:0] a,
                         input logic [16:0] c, input logic [15:0] m,
                         input logic [47:0] s, input logic [16:0] z);
    check(longint'(a) == e.abs_sum, "R5", {tag, " abs_err_sum"}, longint'(a), e.abs_sum);
    check(longint'(c) == e.nz,      "R6", {tag, " err_count"},   longint'(c), e.nz);
    check(longint'(m) == e.maxe,    "R7", {tag, " max_abs_err"}, longint'(m), e.maxe);
    check(longint'(s) == e.sq_sum,  "R8", {tag, " sq_err_sum"},  longint'(s), e.sq_sum);
    check(longint'(z) == e.zeros,   "R9", {tag, " zero_prod_count"}, longint'(z), e.zeros);
  endtask

  // Monitor: pops the expectation when done rises and compares both variants (R4).
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done0 && !done_prev) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3", "done without pending sweep", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(cyc == it.done_cyc, "R3", "done latency cycle", cyc, it.done_cyc);
        check(done1 == 1'b1 && busy0 == 1'b0, "R3", "done/busy pair", {done1, busy0}, 2'b10);
        compare("R4 trunc", it.t_trunc, abs0, cnt0, max0, sq0, zc0);
        compare("R4 or", it.t_or, abs1, cnt1, max1, sq1, zc1);
      end
      completions++;
    end
    done_prev <= done0;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", cyc, WATCHDOG);
    finish_up();
  end

  initial begin
    longint st;
    exp_tr = model(1'b0);
    exp_or = model(1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy0 == 0 && busy1 == 0, "R1", "busy after reset", {busy0, busy1}, 0);
    check(done0 == 0 && done1 == 0, "R1", "done after reset", {done0, done1}, 0);
    check(abs0 == 0 && abs1 == 0, "R1", "abs_err_sum after reset", abs0, 0);
    check(cnt0 == 0 && cnt1 == 0, "R1", "err_count after reset", cnt0, 0);
    check(max0 == 0 && max1 == 0, "R1", "max_abs_err after reset", max0, 0);
    check(sq0 == 0 && sq1 == 0 && zc0 == 0 && zc1 == 0, "R1", "sq/zero after reset", sq0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // First sweep, undisturbed.
    launch();
    check(busy0 == 1 && done0 == 0, "R2", "busy after accepted start", busy0, 1);
    wait (completions == 1);

    // R11: results and done hold while idle.
    repeat (20) @(negedge clk);
    check(done0 == 1 && done1 == 1, "R11", "done held while idle", done0, 1);
    check(longint'(abs0) == exp_tr.abs_sum, "R11", "abs_err_sum held", abs0, exp_tr.abs_sum);
    check(longint'(sq1) == exp_or.sq_sum, "R11", "sq_err_sum held (or)", sq1, exp_or.sq_sum);

    // R11/R2: start while done restarts and clears on the accepting edge.
    st = cyc + 1;
    launch();
    check(done0 == 0 && busy0 == 1, "R11", "restart from done", {done0, busy0}, 2'b01);
    check(abs0 == 0 && cnt0 == 0 && max0 == 0, "R2", "totals cleared (trunc)", abs0, 0);
    check(sq1 == 0 && zc1 == 0 && abs1 == 0, "R2", "totals cleared (or)", abs1, 0);

    // R10: start mid-sweep ignored.
    while (cyc < st + 1000) @(negedge clk);
    pulse_start();
    check(busy0 == 1 && done0 == 0, "R10", "busy kept after mid-sweep start", busy0, 1);
    check(zc0 != 0, "R10", "totals not cleared by mid-sweep start", zc0, 1);

    // R10: start in the same cycle as the last pair.
    while (cyc < st + SWEEP_LEN - 1) @(negedge clk);
    pulse_start();
    wait (completions == 2);
    repeat (3) @(negedge clk);
    check(done0 == 1 && busy0 == 0, "R10", "last-cycle start ignored", {done0, busy0}, 2'b10);
    finish_up();
  end

endmodule